// File: doc/BRIEF.md
# Two-Channel Input Capture Timer

This block keeps a 16-bit up-counter driven by a prescaled tick from the bus clock. The counter runs from zero up to a programmable limit, returns to zero on the next tick and raises an overflow flag. Two capture channels each watch one external pin. When a selected transition appears on a pin, the channel copies the counter value into its own 16-bit capture register and sets its own flag. Each flag has an enable bit, and a flag with its enable set drives an interrupt output.

Software reaches the block through a byte-wide register port. Writes take effect on the clock edge. Reads are combinational. Every 16-bit quantity is read as a high byte and a low byte. Software chooses the tick rate, stops or restarts the counter, sets the wrap limit, picks the edge for each channel and clears the flags. A capture always overwrites the previous value, even when software has not yet serviced the earlier flag.

Top module: `capture_timer`

## Requirements
- R1: After reset the counter reads 0x0000 and the limit reads 0xFFFF. All flags, enables, stop bits, rate bits and edge selects read 0. Both capture registers read 0x0000, and all interrupt outputs are low.
- R2: The control byte at address 0 is laid out as follows: bit7 overflow flag, bit6 overflow enable, bit5 stop, bit4 restart (acts on write, reads 0), bits2:0 rate. Rate values 0 to 6 divide the bus clock by 2^rate, and rate 7 divides by 64. After a write with the restart bit set, the counter reads floor(M/N) M clock cycles later.
- R3: The limit is at address 1 (high byte) and address 2 (low byte). The counter is at address 3 (high byte) and address 4 (low byte). The counter counts 0 up to the limit. The next tick returns it to 0 and sets the overflow flag on that same edge. A limit of 0xFFFF gives a full 65536-count cycle.
- R4: While stop is 1, the counter holds its value. A write with the restart bit set forces the counter and the prescaler to zero, even while the counter is stopped.
- R5: Each channel has a control byte: bit7 flag, bit6 enable, bits1:0 edge select. The edge select codes are 00 none, 01 rising, 10 falling, 11 both. The channel blocks are at base address 5 (channel 0) and base address 8 (channel 1). Each block holds the control byte, then the capture high byte, then the capture low byte.
- R6: Suppose a pin change is first sampled at clock edge k. The capture register and the channel flag update at edge k+2. The value stored is the counter value that was present between edge k+1 and edge k+2.
- R7: A qualifying edge rewrites the capture register even when that channel's flag is already 1.
- R8: Writing 0 to a flag bit clears that flag. Writing 1 to a flag bit leaves it unchanged.
- R9: If a flag is set and a clearing write arrives on the same clock edge, the flag ends up 1.
- R10: Each interrupt output is high exactly when its flag and its enable are both 1.
- R11: A capture on one channel leaves the other channel's capture register and flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| regAddr | input | 4 | Register address |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Combinational read data |
| capPin | input | 2 | Capture pins, one per channel |
| irqOvf | output | 1 | Overflow interrupt request |
| irqCh | output | 2 | Channel interrupt requests |

## Verification
The hardest cases to reach from the ports involve timing. A flag must be set and cleared on one and the same clock edge, and a capture must be checked at the exact edge its two-cycle pipeline lands on. The bench sets up both cases by restarting the counter with a small limit, so the overflow edge falls a known number of cycles later, and then lines up the clearing write with that edge. For captures, the bench reads the running counter in the same half-cycle that it toggles the pin. It then sweeps every channel, every edge code and both transition directions, and predicts the stored value as that reading plus two.

// File: rtl/capt_pkg.sv
`timescale 1ns/1ps
package capt_pkg;
  localparam int CNT_W     = 16;
  localparam int NUM_CH    = 2;
  localparam int RATE_W    = 3;
  localparam int MAX_SHIFT = 6;
  localparam int ADDR_W    = 4;
  localparam int DATA_W    = 8;
  localparam int SYNC_LEN  = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 4'd0;
  localparam logic [ADDR_W-1:0] ADDR_LIM_H = 4'd1;
  localparam logic [ADDR_W-1:0] ADDR_LIM_L = 4'd2;
  localparam logic [ADDR_W-1:0] ADDR_CNT_H = 4'd3;
  localparam logic [ADDR_W-1:0] ADDR_CNT_L = 4'd4;
  localparam int CH_BASE   = 5;
  localparam int CH_STRIDE = 3;

  localparam int BIT_FLAG = 7;
  localparam int BIT_IE   = 6;
  localparam int BIT_STOP = 5;
  localparam int BIT_RST  = 4;

  function automatic logic [ADDR_W-1:0] chAddr(input int ch, input int off);
    return ADDR_W'(CH_BASE + CH_STRIDE * ch + off);
  endfunction

  typedef struct packed {
    logic                          cntClear;
    logic                          cntStop;
    logic [RATE_W-1:0]             rateSel;
    logic [CNT_W-1:0]              limit;
    logic [NUM_CH-1:0][1:0]        edgeSel;
  } ctrl_strobes_t;

  typedef struct packed {
    logic                          ovfEvent;
    logic [NUM_CH-1:0]             capEvent;
    logic [CNT_W-1:0]              count;
    logic [NUM_CH-1:0][CNT_W-1:0]  capVal;
  } dp_status_t;
endpackage

// File: rtl/capt_prescaler.sv
`timescale 1ns/1ps
module capt_prescaler #(
  parameter int RATE_W    = 3,
  parameter int MAX_SHIFT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              hold,
  input  logic [RATE_W-1:0] rateSel,
  output logic              tick
);
  localparam int PS_W = MAX_SHIFT;

  logic [PS_W-1:0] psCnt;
  logic [PS_W-1:0] mask;
  int              shift;

  always_comb begin
    shift = (int'(rateSel) > MAX_SHIFT) ? MAX_SHIFT : int'(rateSel);
    for (int i = 0; i < PS_W; i++) mask[i] = (i < shift);
  end

  assign tick = !hold && !clear && ((psCnt & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      psCnt <= '0;
    else if (clear)  psCnt <= '0;
    else if (!hold)  psCnt <= psCnt + 1'b1;
  end
endmodule

// File: rtl/capt_channel.sv
`timescale 1ns/1ps
module capt_channel #(
  parameter int CNT_W    = 16,
  parameter int SYNC_LEN = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin,
  input  logic [1:0]       edgeSel,
  input  logic [CNT_W-1:0] count,
  output logic             capEvent,
  output logic [CNT_W-1:0] capVal
);
  logic [SYNC_LEN:0] syncQ;
  logic              rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) syncQ <= '0;
    else        syncQ <= {syncQ[SYNC_LEN-1:0], pin};
  end

  assign rise     = syncQ[SYNC_LEN-1] & ~syncQ[SYNC_LEN];
  assign fall     = ~syncQ[SYNC_LEN-1] & syncQ[SYNC_LEN];
  assign capEvent = (edgeSel[0] & rise) | (edgeSel[1] & fall);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        capVal <= '0;
    else if (capEvent) capVal <= count;
  end
endmodule

// File: rtl/capt_datapath.sv
`timescale 1ns/1ps
module capt_datapath import capt_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_strobes_t     ctl,
  input  logic [NUM_CH-1:0] capPin,
  output dp_status_t        sts
);
  logic                          tick;
  logic [CNT_W-1:0]              countQ;
  logic                          atLimit;
  logic [NUM_CH-1:0]             capEv;
  logic [NUM_CH-1:0][CNT_W-1:0]  capV;

  capt_prescaler #(.RATE_W(RATE_W), .MAX_SHIFT(MAX_SHIFT)) u_ps (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (ctl.cntClear),
    .hold    (ctl.cntStop),
    .rateSel (ctl.rateSel),
    .tick    (tick)
  );

  assign atLimit = (countQ == ctl.limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            countQ <= '0;
    else if (ctl.cntClear) countQ <= '0;
    else if (tick)         countQ <= atLimit ? '0 : countQ + 1'b1;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    capt_channel #(.CNT_W(CNT_W), .SYNC_LEN(SYNC_LEN)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin      (capPin[c]),
      .edgeSel  (ctl.edgeSel[c]),
      .count    (countQ),
      .capEvent (capEv[c]),
      .capVal   (capV[c])
    );
  end

  assign sts.ovfEvent = tick & atLimit;
  assign sts.capEvent = capEv;
  assign sts.count    = countQ;
  assign sts.capVal   = capV;
endmodule

// File: rtl/capt_ctrl.sv
`timescale 1ns/1ps
module capt_ctrl import capt_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  dp_status_t        sts,
  output ctrl_strobes_t     ctl,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOvf,
  output logic [NUM_CH-1:0] irqCh
);
  logic                   ovfIe, stopQ, tofFlag;
  logic [RATE_W-1:0]      rateQ;
  logic [CNT_W-1:0]       limitQ;
  logic [NUM_CH-1:0]      chFlag, chIe;
  logic [NUM_CH-1:0][1:0] chSel;
  logic                   ctrlWr;
  logic [NUM_CH-1:0]      chWr;
  logic                   unusedWrBit;

  assign unusedWrBit = wrData[3];
  assign ctrlWr = wrEn && (addr == ADDR_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovfIe   <= 1'b0;
      stopQ   <= 1'b0;
      rateQ   <= '0;
      tofFlag <= 1'b0;
      limitQ  <= '1;
    end else begin
      tofFlag <= sts.ovfEvent | (tofFlag & ~(ctrlWr & ~wrData[BIT_FLAG]));
      if (ctrlWr) begin
        ovfIe <= wrData[BIT_IE];
        stopQ <= wrData[BIT_STOP];
        rateQ <= wrData[RATE_W-1:0];
      end
      if (wrEn && addr == ADDR_LIM_H) limitQ[CNT_W-1:DATA_W] <= wrData;
      if (wrEn && addr == ADDR_LIM_L) limitQ[DATA_W-1:0]     <= wrData;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chreg
    assign chWr[c] = wrEn && (addr == chAddr(c, 0));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chFlag[c] <= 1'b0;
        chIe[c]   <= 1'b0;
        chSel[c]  <= 2'b00;
      end else begin
        chFlag[c] <= sts.capEvent[c] | (chFlag[c] & ~(chWr[c] & ~wrData[BIT_FLAG]));
        if (chWr[c]) begin
          chIe[c]  <= wrData[BIT_IE];
          chSel[c] <= wrData[1:0];
        end
      end
    end
  end

  always_comb begin
    rdData = '0;
    case (addr)
      ADDR_CTRL:  rdData = {tofFlag, ovfIe, stopQ, 2'b00, rateQ};
      ADDR_LIM_H: rdData = limitQ[CNT_W-1:DATA_W];
      ADDR_LIM_L: rdData = limitQ[DATA_W-1:0];
      ADDR_CNT_H: rdData = sts.count[CNT_W-1:DATA_W];
      ADDR_CNT_L: rdData = sts.count[DATA_W-1:0];
      default:    rdData = '0;
    endcase
    for (int c = 0; c < NUM_CH; c++) begin
      if (addr == chAddr(c, 0)) rdData = {chFlag[c], chIe[c], 4'b0000, chSel[c]};
      if (addr == chAddr(c, 1)) rdData = sts.capVal[c][CNT_W-1:DATA_W];
      if (addr == chAddr(c, 2)) rdData = sts.capVal[c][DATA_W-1:0];
    end
  end

  assign ctl.cntClear = ctrlWr & wrData[BIT_RST];
  assign ctl.cntStop  = stopQ;
  assign ctl.rateSel  = rateQ;
  assign ctl.limit    = limitQ;
  assign ctl.edgeSel  = chSel;

  assign irqOvf = tofFlag & ovfIe;
  assign irqCh  = chFlag & chIe;
endmodule

// File: rtl/capture_timer.sv
`timescale 1ns/1ps
module capture_timer import capt_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic [NUM_CH-1:0] capPin,
  output logic              irqOvf,
  output logic [NUM_CH-1:0] irqCh
);
  ctrl_strobes_t ctl;
  dp_status_t    sts;

  capt_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr   (regAddr),
    .wrEn   (regWrEn),
    .wrData (regWrData),
    .sts    (sts),
    .ctl    (ctl),
    .rdData (regRdData),
    .irqOvf (irqOvf),
    .irqCh  (irqCh)
  );

  capt_datapath u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctl    (ctl),
    .capPin (capPin),
    .sts    (sts)
  );
endmodule

// File: rtl/capt_checker.sv
`timescale 1ns/1ps
module capt_checker import capt_pkg::*; (
  input logic                         clk,
  input logic                         rst_n,
  input logic [ADDR_W-1:0]            regAddr,
  input logic                         regWrEn,
  input logic                         wrFlagBit,
  input logic                         clrWr,
  input logic                         stopQ,
  input logic [CNT_W-1:0]             count,
  input logic                         ovfEvent,
  input logic                         tofFlag,
  input logic [NUM_CH-1:0]            capEvent,
  input logic [NUM_CH-1:0]            chFlag,
  input logic [NUM_CH-1:0][CNT_W-1:0] capVal
);
  logic tofClearWr;
  assign tofClearWr = regWrEn && (regAddr == ADDR_CTRL) && !wrFlagBit;

  assert_stop_freezes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stopQ && !clrWr) |=> $stable(count));

  assert_restart_zeroes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clrWr |=> (count == '0));

  assert_set_beats_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovfEvent |=> tofFlag);

  assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tofClearWr && !ovfEvent) |=> !tofFlag);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    assert_capture_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !capEvent[c] |=> $stable(capVal[c]));
    assert_capture_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
      capEvent[c] |=> chFlag[c]);
  end
endmodule

bind capture_timer capt_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .regAddr   (regAddr),
  .regWrEn   (regWrEn),
  .wrFlagBit (regWrData[7]),
  .clrWr     (ctl.cntClear),
  .stopQ     (ctl.cntStop),
  .count     (sts.count),
  .ovfEvent  (sts.ovfEvent),
  .tofFlag   (u_ctrl.tofFlag),
  .capEvent  (sts.capEvent),
  .chFlag    (u_ctrl.chFlag),
  .capVal    (sts.capVal)
);

// File: tb/tb_capture_timer.sv
`timescale 1ns/1ps
module tb_capture_timer;
  import capt_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] regAddr = '0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic [1:0] capPin = '0;
  logic       irqOvf;
  logic [1:0] irqCh;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  capture_timer dut (
    .clk(clk), .rst_n(rst_n), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .capPin(capPin),
    .irqOvf(irqOvf), .irqCh(irqCh)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd8(input logic [3:0] a, output logic [7:0] v);
    regAddr = a;
    #1;
    v = regRdData;
  endtask

  task automatic rd16(input logic [3:0] hi, output logic [15:0] v);
    logic [7:0] h, l;
    rd8(hi, h);
    rd8(4'(hi + 1), l);
    v = {h, l};
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] w, c, prev, other;

    // R1: reset state, read while reset is held
    repeat (2) @(negedge clk);
    rd16(ADDR_CNT_H, w); check("R1 counter", w, 16'h0000);
    rd16(ADDR_LIM_H, w); check("R1 limit", w, 16'hFFFF);
    @(negedge clk);
    rd8(ADDR_CTRL, b); check("R1 control", {8'h0, b}, 16'h0000);
    rd8(chAddr(0, 0), b); check("R1 ch0 control", {8'h0, b}, 16'h0000);
    rd8(chAddr(1, 0), b); check("R1 ch1 control", {8'h0, b}, 16'h0000);
    @(negedge clk);
    rd16(chAddr(0, 1), w); check("R1 ch0 capture", w, 16'h0000);
    rd16(chAddr(1, 1), w); check("R1 ch1 capture", w, 16'h0000);
    check("R1 irq", {13'h0, irqOvf, irqCh}, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: prescaler rates, restart plus rate in one write
    for (int sel = 0; sel < 8; sel++) begin
      int n;
      n = 1 << ((sel > 6) ? 6 : sel);
      wr(ADDR_CTRL, 8'h10 | 8'(sel));
      repeat (100) @(negedge clk);
      rd16(ADDR_CNT_H, w);
      check($sformatf("R2 rate %0d", sel), w, 16'(100 / n));
    end
    rd8(ADDR_CTRL, b); check("R2 control readback", {8'h0, b}, 16'h0007);

    // R4: stop holds, restart while stopped zeroes
    wr(ADDR_CTRL, 8'h20);
    rd16(ADDR_CNT_H, c);
    repeat (10) @(negedge clk);
    rd16(ADDR_CNT_H, w); check("R4 stop holds", w, c);
    wr(ADDR_CTRL, 8'h30);
    repeat (5) @(negedge clk);
    rd16(ADDR_CNT_H, w); check("R4 restart while stopped", w, 16'h0000);

    // R3: small limit wrap, R10 overflow interrupt
    wr(ADDR_LIM_H, 8'h00);
    wr(ADDR_LIM_L, 8'h05);
    rd16(ADDR_LIM_H, w); check("R3 limit readback", w, 16'h0005);
    wr(ADDR_CTRL, 8'h50);
    repeat (5) @(negedge clk);
    rd16(ADDR_CNT_H, w); check("R3 at limit", w, 16'h0005);
    rd8(ADDR_CTRL, b); check("R3 flag before wrap", {15'h0, b[7]}, 16'h0000);
    @(negedge clk);
    rd16(ADDR_CNT_H, w); check("R3 wrapped", w, 16'h0000);
    rd8(ADDR_CTRL, b); check("R3 flag on wrap", {15'h0, b[7]}, 16'h0001);
    check("R10 overflow irq", {15'h0, irqOvf}, 16'h0001);

    // R8: write 1 keeps, write 0 clears
    wr(ADDR_CTRL, 8'hC0);
    rd8(ADDR_CTRL, b); check("R8 write one keeps", {15'h0, b[7]}, 16'h0001);
    wr(ADDR_CTRL, 8'h40);
    rd8(ADDR_CTRL, b); check("R8 write zero clears", {15'h0, b[7]}, 16'h0000);
    check("R10 irq follows flag", {15'h0, irqOvf}, 16'h0000);

    // R9: clear on the same edge as the wrap
    wr(ADDR_CTRL, 8'h50);
    repeat (5) @(negedge clk);
    wr(ADDR_CTRL, 8'h40);
    rd8(ADDR_CTRL, b); check("R9 set wins", {15'h0, b[7]}, 16'h0001);
    wr(ADDR_CTRL, 8'h80);
    check("R10 enable off masks irq", {15'h0, irqOvf}, 16'h0000);
    rd8(ADDR_CTRL, b); check("R10 flag kept", {15'h0, b[7]}, 16'h0001);

    // back to full range, divide by 1, flag cleared
    wr(ADDR_LIM_H, 8'hFF);
    wr(ADDR_LIM_L, 8'hFF);
    wr(ADDR_CTRL, 8'h10);

    // R5 R6 R10 R11: sweep channel, edge code, direction
    for (int ch = 0; ch < 2; ch++) begin
      for (int sel = 0; sel < 4; sel++) begin
        for (int dir = 0; dir < 2; dir++) begin
          logic startLvl, fire;
          startLvl = (dir == 1);
          fire = (dir == 0) ? sel[0] : sel[1];
          capPin[ch] = startLvl;
          repeat (4) @(negedge clk);
          wr(chAddr(ch, 0), 8'h40 | 8'(sel));
          rd16(chAddr(ch, 1), prev);
          rd16(chAddr(1 - ch, 1), other);
          @(negedge clk);
          rd16(ADDR_CNT_H, c);
          capPin[ch] = ~startLvl;
          repeat (2) @(negedge clk);
          rd8(chAddr(ch, 0), b);
          check($sformatf("R6 ch%0d sel%0d dir%0d no early flag", ch, sel, dir),
                {15'h0, b[7]}, 16'h0000);
          @(negedge clk);
          rd8(chAddr(ch, 0), b);
          check($sformatf("R5 ch%0d sel%0d dir%0d control", ch, sel, dir),
                {8'h0, b}, {8'h0, fire, 1'b1, 4'b0, 2'(sel)});
          rd16(chAddr(ch, 1), w);
          check($sformatf("R6 ch%0d sel%0d dir%0d capture", ch, sel, dir),
                w, fire ? 16'(c + 16'd2) : prev);
          check($sformatf("R10 ch%0d sel%0d dir%0d irq", ch, sel, dir),
                {15'h0, irqCh[ch]}, {15'h0, fire});
          @(negedge clk);
          rd16(chAddr(1 - ch, 1), w);
          check($sformatf("R11 ch%0d sel%0d dir%0d other channel", ch, sel, dir), w, other);
        end
      end
    end

    // R7: overwrite while flag is set
    wr(chAddr(0, 0), 8'h43);
    @(negedge clk);
    rd16(ADDR_CNT_H, c);
    capPin[0] = ~capPin[0];
    repeat (3) @(negedge clk);
    rd16(chAddr(0, 1), w); check("R7 first capture", w, 16'(c + 16'd2));
    repeat (5) @(negedge clk);
    rd16(ADDR_CNT_H, c);
    capPin[0] = ~capPin[0];
    repeat (3) @(negedge clk);
    rd16(chAddr(0, 1), w); check("R7 overwrite with flag set", w, 16'(c + 16'd2));
    rd8(chAddr(0, 0), b); check("R7 flag still set", {15'h0, b[7]}, 16'h0001);
    wr(chAddr(0, 0), 8'h83);
    check("R10 ch0 enable off", {15'h0, irqCh[0]}, 16'h0000);
    rd8(chAddr(0, 0), b); check("R8 ch0 write one keeps", {15'h0, b[7]}, 16'h0001);
    wr(chAddr(0, 0), 8'h03);
    rd8(chAddr(0, 0), b); check("R8 ch0 write zero clears", {15'h0, b[7]}, 16'h0000);

    // R3: full 16-bit wrap at limit 0xFFFF
    wr(ADDR_CTRL, 8'h10);
    repeat (65535) @(negedge clk);
    rd16(ADDR_CNT_H, w); check("R3 full count", w, 16'hFFFF);
    rd8(ADDR_CTRL, b); check("R3 no flag at top", {15'h0, b[7]}, 16'h0000);
    @(negedge clk);
    rd16(ADDR_CNT_H, w); check("R3 full wrap", w, 16'h0000);
    rd8(ADDR_CTRL, b); check("R3 flag on full wrap", {15'h0, b[7]}, 16'h0001);

    summary();
  end
endmodule